// File: doc/BRIEF.md
# Multi-Channel Supervisory Reset Controller

This block produces four active-low reset outputs for the parts of a system that run from different supply rails. Each output is driven by its own rail condition, plus two sources shared by all outputs. The rail condition comes from an external comparator pair that gives an under-voltage flag and an over-voltage flag. A per-channel polarity bit chooses which of the two flags counts, and a per-channel enable decides whether that channel may pull its own output. The shared sources are an unmaskable manual reset input and a watchdog expiry pulse.

When every source of an output has gone away, the output stays low for a programmable stretch time before it releases. That time is counted on a 1 ms tick input, and a 2-bit code selects 25, 50, 100 or 200 ticks. A sticky fault nibble records which rails went out of range. A host clears it with a strobe.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, all four reset outputs are low and the fault nibble is 0. Release happens as for a cleared source (R6), with the timeout selected at that time.
- R2: The condition of channel k is uv_i[k] when ov_sel_i[k]=0 and ov_i[k] when ov_sel_i[k]=1. The unselected flag has no effect on the outputs or the fault nibble.
- R3: With trig_en_i[k]=1, the condition of channel k pulls only rst_no[k] low, one clock after the condition is sampled. With trig_en_i[k]=0 it pulls no output.
- R4: mr_ni low pulls all four outputs low one clock later and holds them low for as long as it stays low, whatever the enables are.
- R5: A single-cycle wd_expire_i pulse pulls all four outputs low one clock later.
- R6: After the last source of an output goes inactive, the output stays low until it has counted N tick_i pulses with no source active, and it goes high on the clock edge of the N-th such tick. Cycles without a tick do not advance the count.
- R7: tmo_sel_i values 0, 1, 2 and 3 give N = 25, 50, 100 and 200.
- R8: A source that reasserts during the stretch restarts the count from zero.
- R9: fault_o[k] is set one clock after the selected condition of channel k is seen, whatever trig_en_i[k] is, and stays set after the condition clears.
- R10: A stat_clr_i strobe clears every fault bit whose channel condition is absent in that cycle. A bit whose condition is still present stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 ms timing enable |
| uv_i | input | 4 | Per-channel under-voltage flags |
| ov_i | input | 4 | Per-channel over-voltage flags |
| ov_sel_i | input | 4 | Per-channel polarity: 0 selects UV, 1 selects OV |
| trig_en_i | input | 4 | Per-channel permission to drive its own output |
| tmo_sel_i | input | 2 | Stretch-time code (25/50/100/200 ticks) |
| mr_ni | input | 1 | Manual reset, active low, affects all outputs |
| wd_expire_i | input | 1 | Watchdog expiry pulse, affects all outputs |
| stat_clr_i | input | 1 | Fault nibble clear strobe |
| rst_no | output | 4 | Active-low reset outputs |
| fault_o | output | 4 | Sticky per-channel fault flags |

## Verification
The hardest cases to reach are the count boundaries of the stretch. There are two of them: the exact edge of the N-th tick, and the restart when a source returns partway through the count. The bench holds tick_i high so that ticks equal cycles. It then sweeps every timeout code, channel and polarity, and checks each output one cycle before and exactly at the computed release. A retrigger placed mid-stretch must push the release out by a full period. A long stretch of cycles with tick_i held low must leave the output low.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  typedef enum logic [1:0] {
    TMO_X1 = 2'd0,
    TMO_X2 = 2'd1,
    TMO_X4 = 2'd2,
    TMO_X8 = 2'd3
  } tmo_sel_e;

  function automatic int unsigned tmo_ticks(int unsigned base, tmo_sel_e sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/chan_cond.sv
module chan_cond #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] uv_i,
  input  logic [NUM_CH-1:0] ov_i,
  input  logic [NUM_CH-1:0] ov_sel_i,
  input  logic [NUM_CH-1:0] trig_en_i,
  output logic [NUM_CH-1:0] cond_o,
  output logic [NUM_CH-1:0] trig_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    // polarity is exclusive: only the selected flag is seen
    assign cond_o[k] = ov_sel_i[k] ? ov_i[k] : uv_i[k];
    assign trig_o[k] = cond_o[k] & trig_en_i[k];
  end
endmodule

// File: rtl/reset_stretch.sv
module reset_stretch
  import sup_rst_pkg::*;
#(
  parameter int BASE_TICKS = 25,
  localparam int MAX_TICKS = BASE_TICKS * 8,
  localparam int CNT_W     = $clog2(MAX_TICKS)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     src_i,
  input  tmo_sel_e tmo_sel_i,
  output logic     active_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1 = CNT_W'(tmo_ticks(BASE_TICKS, tmo_sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (src_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      // >= so a shorter code selected mid-stretch still releases
      if (cnt_q >= lim_m1) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R3
  src_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i |=> active_q);
  // R6
  release_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> (!$past(src_i) && $past(tick_i)));
  // R8
  idle_cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (cnt_q == '0));
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < MAX_TICKS);
endmodule

// File: rtl/fault_status.sv
module fault_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cond_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] fault_o
);
  logic [NUM_CH-1:0] fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= '0;
    else         fault_q <= cond_i | (fault_q & {NUM_CH{~clr_i}});
  end

  assign fault_o = fault_q;

  // R9
  fault_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i != '0) |=> ((fault_q & $past(cond_i)) == $past(cond_i)));
  // R10
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_rst_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int BASE_TICKS = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] uv_i,
  input  logic [NUM_CH-1:0] ov_i,
  input  logic [NUM_CH-1:0] ov_sel_i,
  input  logic [NUM_CH-1:0] trig_en_i,
  input  logic [1:0]        tmo_sel_i,
  input  logic              mr_ni,
  input  logic              wd_expire_i,
  input  logic              stat_clr_i,
  output logic [NUM_CH-1:0] rst_no,
  output logic [NUM_CH-1:0] fault_o
);
  logic [NUM_CH-1:0] cond;
  logic [NUM_CH-1:0] trig;
  logic [NUM_CH-1:0] src;
  logic [NUM_CH-1:0] active;
  logic              global_src;
  tmo_sel_e          tmo_sel;

  assign tmo_sel    = tmo_sel_e'(tmo_sel_i);
  // manual reset and watchdog cannot be masked
  assign global_src = ~mr_ni | wd_expire_i;

  chan_cond #(.NUM_CH(NUM_CH)) u_cond (
    .uv_i      (uv_i),
    .ov_i      (ov_i),
    .ov_sel_i  (ov_sel_i),
    .trig_en_i (trig_en_i),
    .cond_o    (cond),
    .trig_o    (trig)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_out
    assign src[k] = global_src | trig[k];
    reset_stretch #(.BASE_TICKS(BASE_TICKS)) u_stretch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .src_i     (src[k]),
      .tmo_sel_i (tmo_sel),
      .active_o  (active[k])
    );
  end

  assign rst_no = ~active;

  fault_status #(.NUM_CH(NUM_CH)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_i  (cond),
    .clr_i   (stat_clr_i),
    .fault_o (fault_o)
  );

  // R4
  mr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_ni |=> (rst_no == '0));
  // R5
  wd_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire_i |=> (rst_no == '0));
  // R2
  pol_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == '0 && ((uv_i & ov_sel_i) | (ov_i & ~ov_sel_i)) == uv_i | ov_i
     && !mr_ni == 1'b0 && !wd_expire_i && (((uv_i & ~ov_sel_i) | (ov_i & ov_sel_i)) == '0))
    |=> (fault_o == '0));
endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b1;
  logic [NCH-1:0] uv_i = '0, ov_i = '0, ov_sel_i = '0, trig_en_i = '1;
  logic [1:0]     tmo_sel_i = 2'd0;
  logic           mr_ni = 1'b1, wd_expire_i = 1'b0, stat_clr_i = 1'b0;
  logic [NCH-1:0] rst_no, fault_o;

  int checks = 0;
  int failures = 0;

  sup_reset_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .uv_i(uv_i), .ov_i(ov_i),
    .ov_sel_i(ov_sel_i), .trig_en_i(trig_en_i), .tmo_sel_i(tmo_sel_i),
    .mr_ni(mr_ni), .wd_expire_i(wd_expire_i), .stat_clr_i(stat_clr_i),
    .rst_no(rst_no), .fault_o(fault_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int code);
    return 25 << code;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 rst", rst_no, 4'h0);
    chk("R1 fault", fault_o, 4'h0);
    rst_ni = 1'b1;
    step(24);
    chk("R1 held", rst_no, 4'h0);
    step(1);
    chk("R1 release", rst_no, 4'hF);

    // sweep of code, channel and polarity: R2 R3 R6 R7 R9 R10
    for (int code = 0; code < 4; code++) begin
      for (int k = 0; k < NCH; k++) begin
        for (int p = 0; p < 2; p++) begin
          logic [3:0] one;
          int lim;
          one = 4'b0001 << k;
          lim = lim_of(code);
          tmo_sel_i = code[1:0];
          ov_sel_i = p ? one : 4'h0;
          if (p != 0) uv_i = one; else ov_i = one;
          step(2);
          chk("R2 wrong flag out", rst_no, 4'hF);
          chk("R2 wrong flag status", fault_o, 4'h0);
          uv_i = '0; ov_i = '0;
          if (p != 0) ov_i = one; else uv_i = one;
          step(1);
          chk("R3 own output", rst_no, ~one);
          chk("R9 status set", fault_o, one);
          uv_i = '0; ov_i = '0;
          step(lim - 1);
          chk("R7 before release", rst_no, ~one);
          step(1);
          chk("R7 release", rst_no, 4'hF);
          chk("R9 sticky", fault_o, one);
          stat_clr_i = 1'b1;
          step(1);
          stat_clr_i = 1'b0;
          chk("R10 cleared", fault_o, 4'h0);
        end
      end
    end
    tmo_sel_i = 2'd0; ov_sel_i = '0;

    // R3 disabled channel: no output, still monitored
    trig_en_i = 4'b1101;
    uv_i = 4'b0010;
    step(5);
    chk("R3 disabled out", rst_no, 4'hF);
    chk("R9 disabled monitored", fault_o, 4'b0010);
    // R10 clear with condition present keeps bit
    stat_clr_i = 1'b1;
    step(1);
    stat_clr_i = 1'b0;
    chk("R10 present kept", fault_o, 4'b0010);
    uv_i = '0;
    stat_clr_i = 1'b1;
    step(1);
    stat_clr_i = 1'b0;
    chk("R10 absent cleared", fault_o, 4'h0);
    trig_en_i = '1;

    // R4 manual reset with all enables off
    trig_en_i = '0;
    mr_ni = 1'b0;
    step(1);
    chk("R4 mr asserts", rst_no, 4'h0);
    step(40);
    chk("R4 mr holds", rst_no, 4'h0);
    mr_ni = 1'b1;
    step(24);
    chk("R4 stretch", rst_no, 4'h0);
    step(1);
    chk("R4 release", rst_no, 4'hF);
    trig_en_i = '1;

    // R5 watchdog pulse
    wd_expire_i = 1'b1;
    step(1);
    wd_expire_i = 1'b0;
    chk("R5 wd asserts", rst_no, 4'h0);
    step(24);
    chk("R5 stretch", rst_no, 4'h0);
    step(1);
    chk("R5 release", rst_no, 4'hF);

    // R8 retrigger restarts count
    uv_i = 4'b0001;
    step(1);
    uv_i = '0;
    step(10);
    uv_i = 4'b0001;
    step(1);
    uv_i = '0;
    step(24);
    chk("R8 after restart", rst_no, 4'b1110);
    step(1);
    chk("R8 release", rst_no, 4'hF);

    // R6 no tick, no count
    uv_i = 4'b0100;
    step(1);
    uv_i = '0;
    tick_i = 1'b0;
    step(300);
    chk("R6 no tick holds", rst_no, 4'b1011);
    tick_i = 1'b1;
    step(24);
    chk("R6 tick resumes", rst_no, 4'b1011);
    step(1);
    chk("R6 release", rst_no, 4'hF);
    stat_clr_i = 1'b1;
    step(1);
    stat_clr_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule